// File: doc/BRIEF.md
# 1-Wire ROM Selection Layer

This block runs the network-selection phase of a 1-Wire slave. It sits between a bit engine, which times the wire and reports each completed time slot and each detected reset pulse, and the memory command layer, which takes over once this slave has been chosen. After every bus reset it collects one 8-bit command, least significant bit first. It then either returns its 64-bit identifier, compares an identifier sent by the master, takes part in a search, or selects itself at once. The identifier is built at elaboration from a family code and a serial number given as parameters, with a CRC-8 appended.

The layer also keeps two flags across bus resets. The resume flag lets a master that has already addressed this slave select it again with a one-byte command. The overdrive flag tells the bit engine to switch to the fast slot timing. When selection fails, the slave releases the wire and ignores every slot until the next reset.

For each slot, the bit the slave wants on the wire is presented on `tx_bit` before the slot strobe, with 1 meaning released. The bit engine returns the level it sampled on the wire in `slot_rx`.

Top module: `owrom_select`

## Requirements
- R1: The identifier goes out in bit order 0 to 63. Bits 0..7 hold the family code, bits 8..55 hold the serial number, and bits 56..63 hold a CRC-8 with polynomial x^8+x^5+x^4+1. The CRC starts from an all-zero register and is fed the first 56 bits in send order, so running it over all 64 bits leaves zero.
- R2: The first 8 slots after a bus reset form the command byte, least significant bit first. Accepted codes: 33h read, 55h match, F0h search, CCh skip, A5h resume, 3Ch overdrive-skip, 69h overdrive-match. Before the first bus reset, and while idle, slots are ignored and `tx_bit` stays 1.
- R3: After 33h, the next 64 slots carry identifier bits on `tx_bit`, one per slot. The slave is then selected. The resume flag is cleared at decode.
- R4: After 55h, the next 64 slots are compared with the identifier. A full match selects the slave and sets the resume flag. At the first mismatching bit the slave goes idle and clears the resume flag, and later bits cannot select it.
- R5: After F0h, each identifier bit uses three slots. The slave drives the bit, then its complement, then reads the master's bit. A wrong master bit sends the slave idle and clears the resume flag. Completing all 64 triplets selects it and sets the resume flag.
- R6: CCh selects the slave at once and clears the resume flag.
- R7: A5h selects the slave when the resume flag is 1 and leaves the flag at 1. When the flag is 0, the slave goes idle.
- R8: 3Ch sets the overdrive flag, clears the resume flag and selects the slave.
- R9: 69h sets the overdrive flag from the cycle after decode, then compares 64 bits as in R4. On a match the slave is selected with both flags at 1. On a mismatch the resume flag is cleared and the overdrive flag returns to the value it had before the command.
- R10: Any other code sends the slave idle and leaves both flags unchanged.
- R11: A bus reset in any state restarts command collection. A slot strobe in the same cycle as the reset is dropped. An aborted command leaves the resume flag unchanged, and an aborted overdrive-match restores the overdrive flag.
- R12: `mem_sel` rises in the cycle after the deciding slot and stays high, with `tx_bit`=1, until the cycle after the next bus reset.
- R13: While `rst_n` is low the slave is idle with `mem_sel`=0, `rc_flag`=0, `od_mode`=0 and `tx_bit`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| bus_rst | input | 1 | One-cycle pulse: bit engine saw a reset pulse on the wire |
| slot_stb | input | 1 | One-cycle pulse: a time slot has completed |
| slot_rx | input | 1 | Wire level sampled in that slot |
| tx_bit | output | 1 | Bit the slave drives in the next slot (1 = released) |
| mem_sel | output | 1 | Selection succeeded; memory layer owns the bus |
| rc_flag | output | 1 | Resume flag |
| od_mode | output | 1 | Overdrive flag for the bit engine |

## Verification
A bus reset and a slot strobe can fall in the same clock cycle. The reset must win, and the slot bit must not enter the new command byte. The bench provokes this by raising both inputs in one cycle and then sending CCh. If the stray bit were counted, the byte seen would be 99h and the slave would go idle. So the judgement is that `mem_sel` rises exactly after the eighth following slot, and the per-clock reference model agrees on every output throughout.

// File: rtl/owrom_pkg.sv
package owrom_pkg;

    localparam int FAM_W  = 8;
    localparam int SER_W  = 48;
    localparam int CRC_W  = 8;
    localparam int BODY_W = FAM_W + SER_W;
    localparam int ID_W   = BODY_W + CRC_W;
    localparam int IDX_W  = $clog2(ID_W);
    localparam int CODE_W = 8;
    localparam int CBIT_W = $clog2(CODE_W);

    localparam logic [CODE_W-1:0] CODE_READ    = 8'h33;
    localparam logic [CODE_W-1:0] CODE_MATCH   = 8'h55;
    localparam logic [CODE_W-1:0] CODE_SEARCH  = 8'hF0;
    localparam logic [CODE_W-1:0] CODE_SKIP    = 8'hCC;
    localparam logic [CODE_W-1:0] CODE_RESUME  = 8'hA5;
    localparam logic [CODE_W-1:0] CODE_ODSKIP  = 8'h3C;
    localparam logic [CODE_W-1:0] CODE_ODMATCH = 8'h69;

    // reflected form of x^8+x^5+x^4+1
    localparam logic [CRC_W-1:0] CRC_POLY_REFL = 8'h8C;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_READ,
        ST_MATCH,
        ST_SEARCH,
        ST_SEL
    } state_e;

    typedef enum logic [2:0] {
        CMD_READ,
        CMD_MATCH,
        CMD_SEARCH,
        CMD_SKIP,
        CMD_RESUME,
        CMD_ODSKIP,
        CMD_ODMATCH,
        CMD_BAD
    } cmd_e;

    typedef enum logic [1:0] {
        PH_TRUE,
        PH_COMP,
        PH_DIR
    } phase_e;

    function automatic logic [CRC_W-1:0] crc8_lsb(input logic [BODY_W-1:0] body);
        logic [CRC_W-1:0] r;
        logic             fb;
        r = '0;
        for (int i = 0; i < BODY_W; i++) begin
            fb = r[0] ^ body[i];
            r  = r >> 1;
            if (fb) r = r ^ CRC_POLY_REFL;
        end
        return r;
    endfunction

endpackage

// File: rtl/owrom_id_rom.sv
module owrom_id_rom
    import owrom_pkg::*;
#(
    parameter logic [FAM_W-1:0] FAMILY_CODE = 8'h4A,
    parameter logic [SER_W-1:0] SERIAL_NUM  = 48'h0000_0000_0001
) (
    input  logic [IDX_W-1:0] bit_idx,
    output logic             id_bit
);
    localparam logic [BODY_W-1:0] BODY    = {SERIAL_NUM, FAMILY_CODE};
    localparam logic [CRC_W-1:0]  CRC     = crc8_lsb(BODY);
    localparam logic [ID_W-1:0]   ID_WORD = {CRC, BODY};

    assign id_bit = ID_WORD[bit_idx];
endmodule

// File: rtl/owrom_cmd_decode.sv
module owrom_cmd_decode
    import owrom_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output cmd_e              kind
);
    always_comb begin
        unique case (code)
            CODE_READ:    kind = CMD_READ;
            CODE_MATCH:   kind = CMD_MATCH;
            CODE_SEARCH:  kind = CMD_SEARCH;
            CODE_SKIP:    kind = CMD_SKIP;
            CODE_RESUME:  kind = CMD_RESUME;
            CODE_ODSKIP:  kind = CMD_ODSKIP;
            CODE_ODMATCH: kind = CMD_ODMATCH;
            default:      kind = CMD_BAD;
        endcase
    end
endmodule

// File: rtl/owrom_select.sv
module owrom_select
    import owrom_pkg::*;
#(
    parameter logic [FAM_W-1:0] FAMILY_CODE = 8'h4A,
    parameter logic [SER_W-1:0] SERIAL_NUM  = 48'h3C91_05E7_22B8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_rst,
    input  logic slot_stb,
    input  logic slot_rx,
    output logic tx_bit,
    output logic mem_sel,
    output logic rc_flag,
    output logic od_mode
);
    localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(ID_W - 1);
    localparam logic [CBIT_W-1:0] LAST_CBIT = CBIT_W'(CODE_W - 1);

    typedef struct packed {
        state_e              st;
        logic [IDX_W-1:0]    idx;
        logic [CBIT_W-1:0]   cbit;
        phase_e              ph;
        logic [CODE_W-1:0]   sh;
        logic                rc;
        logic                od;
        logic                od_keep;
        logic                odm;
    } fsm_t;

    localparam fsm_t FSM_RST = '{
        st:      ST_IDLE,
        idx:     '0,
        cbit:    '0,
        ph:      PH_TRUE,
        sh:      '0,
        rc:      1'b0,
        od:      1'b0,
        od_keep: 1'b0,
        odm:     1'b0
    };

    fsm_t q, d;

    logic [CODE_W-1:0] full_code;
    cmd_e              kind;
    logic              id_bit;

    assign full_code = {slot_rx, q.sh[CODE_W-1:1]};

    owrom_cmd_decode u_dec (
        .code (full_code),
        .kind (kind)
    );

    owrom_id_rom #(
        .FAMILY_CODE (FAMILY_CODE),
        .SERIAL_NUM  (SERIAL_NUM)
    ) u_id (
        .bit_idx (q.idx),
        .id_bit  (id_bit)
    );

    always_comb begin
        d = q;
        if (bus_rst) begin
            // abort: an interrupted overdrive-match puts OD back
            if (q.st == ST_MATCH && q.odm) d.od = q.od_keep;
            d.st   = ST_CMD;
            d.idx  = '0;
            d.cbit = '0;
            d.ph   = PH_TRUE;
            d.odm  = 1'b0;
        end else if (slot_stb) begin
            unique case (q.st)
                ST_CMD: begin
                    d.sh   = full_code;
                    d.cbit = q.cbit + 1'b1;
                    if (q.cbit == LAST_CBIT) begin
                        d.cbit = '0;
                        d.idx  = '0;
                        d.ph   = PH_TRUE;
                        unique case (kind)
                            CMD_READ: begin
                                d.st = ST_READ;
                                d.rc = 1'b0;
                            end
                            CMD_MATCH: begin
                                d.st  = ST_MATCH;
                                d.odm = 1'b0;
                            end
                            CMD_SEARCH: d.st = ST_SEARCH;
                            CMD_SKIP: begin
                                d.st = ST_SEL;
                                d.rc = 1'b0;
                            end
                            CMD_RESUME: d.st = q.rc ? ST_SEL : ST_IDLE;
                            CMD_ODSKIP: begin
                                d.st = ST_SEL;
                                d.rc = 1'b0;
                                d.od = 1'b1;
                            end
                            CMD_ODMATCH: begin
                                d.st      = ST_MATCH;
                                d.odm     = 1'b1;
                                d.od_keep = q.od;
                                d.od      = 1'b1;
                            end
                            default: d.st = ST_IDLE;
                        endcase
                    end
                end
                ST_READ: begin
                    d.idx = q.idx + 1'b1;
                    if (q.idx == LAST_IDX) d.st = ST_SEL;
                end
                ST_MATCH: begin
                    if (slot_rx != id_bit) begin
                        d.st  = ST_IDLE;
                        d.rc  = 1'b0;
                        d.odm = 1'b0;
                        if (q.odm) d.od = q.od_keep;
                    end else if (q.idx == LAST_IDX) begin
                        d.st  = ST_SEL;
                        d.rc  = 1'b1;
                        d.odm = 1'b0;
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
                ST_SEARCH: begin
                    unique case (q.ph)
                        PH_TRUE: d.ph = PH_COMP;
                        PH_COMP: d.ph = PH_DIR;
                        default: begin
                            d.ph = PH_TRUE;
                            if (slot_rx != id_bit) begin
                                d.st = ST_IDLE;
                                d.rc = 1'b0;
                            end else if (q.idx == LAST_IDX) begin
                                d.st = ST_SEL;
                                d.rc = 1'b1;
                            end else begin
                                d.idx = q.idx + 1'b1;
                            end
                        end
                    endcase
                end
                default: d = q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= FSM_RST;
        else        q <= d;
    end

    always_comb begin
        unique case (q.st)
            ST_READ:   tx_bit = id_bit;
            ST_SEARCH: tx_bit = (q.ph == PH_TRUE) ? id_bit :
                                (q.ph == PH_COMP) ? ~id_bit : 1'b1;
            default:   tx_bit = 1'b1;
        endcase
    end

    assign mem_sel = (q.st == ST_SEL);
    assign rc_flag = q.rc;
    assign od_mode = q.od;

endmodule

// File: rtl/owrom_select_chk.sv
module owrom_select_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_rst,
    input logic slot_stb,
    input logic tx_bit,
    input logic mem_sel,
    input logic rc_flag,
    input logic od_mode
);
    // R12
    sel_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_sel |-> tx_bit);

    // R11
    rst_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |=> !mem_sel);

    // R12
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_sel) |-> $past(bus_rst));

    // R4
    rc_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rc_flag) |-> mem_sel);

    // R2
    rc_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rc_flag) |-> ($past(slot_stb) && !$past(bus_rst)));

    // R9
    od_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(od_mode) |-> $past(slot_stb || bus_rst));

    // R12
    sel_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_sel) |-> ($past(slot_stb) && !$past(bus_rst)));
endmodule

bind owrom_select owrom_select_chk u_chk (.*);

// File: tb/owrom_select_tb.sv
module owrom_select_tb;
    localparam logic [7:0]  FAM = 8'h4A;
    localparam logic [47:0] SER = 48'h3C91_05E7_22B8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_rst = 1'b0;
    logic slot_stb = 1'b0;
    logic slot_rx = 1'b1;
    logic tx_bit, mem_sel, rc_flag, od_mode;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    owrom_select #(.FAMILY_CODE(FAM), .SERIAL_NUM(SER)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .slot_stb(slot_stb),
        .slot_rx(slot_rx), .tx_bit(tx_bit), .mem_sel(mem_sel),
        .rc_flag(rc_flag), .od_mode(od_mode)
    );

    // expected identifier, send order
    bit idb [64];
    initial begin
        int c;
        c = 0;
        for (int i = 0; i < 56; i++) begin
            idb[i] = (i < 8) ? FAM[i] : SER[i-8];
            if (((c ^ idb[i]) & 1) != 0) c = (c >> 1) ^ 'h8C;
            else c = c >> 1;
        end
        for (int i = 0; i < 8; i++) idb[56+i] = c[i];
    end

    // behavioural reference model: 0 idle 1 cmd 2 read 3 match 4 search 5 sel
    int m_st, m_n, m_ph, m_code, m_rc, m_od, m_keep, m_odm;

    function automatic bit m_tx();
        if (m_st == 2) return idb[m_n];
        if (m_st == 4 && m_ph == 0) return idb[m_n];
        if (m_st == 4 && m_ph == 1) return !idb[m_n];
        return 1'b1;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_n = 0; m_ph = 0; m_code = 0;
            m_rc = 0; m_od = 0; m_keep = 0; m_odm = 0;
        end else if (bus_rst) begin
            if (m_st == 3 && m_odm == 1) m_od = m_keep;
            m_st = 1; m_n = 0; m_ph = 0; m_code = 0; m_odm = 0;
        end else if (slot_stb) begin
            if (m_st == 1) begin
                m_code = m_code | (int'(slot_rx) << m_n);
                m_n++;
                if (m_n == 8) begin
                    m_n = 0;
                    case (m_code)
                        'h33: begin m_st = 2; m_rc = 0; end
                        'h55: m_st = 3;
                        'hF0: m_st = 4;
                        'hCC: begin m_st = 5; m_rc = 0; end
                        'hA5: m_st = (m_rc == 1) ? 5 : 0;
                        'h3C: begin m_st = 5; m_rc = 0; m_od = 1; end
                        'h69: begin m_st = 3; m_odm = 1; m_keep = m_od; m_od = 1; end
                        default: m_st = 0;
                    endcase
                end
            end else if (m_st == 2) begin
                if (m_n == 63) m_st = 5; else m_n++;
            end else if (m_st == 3) begin
                if (slot_rx != idb[m_n]) begin
                    m_st = 0; m_rc = 0;
                    if (m_odm == 1) m_od = m_keep;
                    m_odm = 0;
                end else if (m_n == 63) begin
                    m_st = 5; m_rc = 1; m_odm = 0;
                end else m_n++;
            end else if (m_st == 4) begin
                if (m_ph < 2) m_ph++;
                else begin
                    m_ph = 0;
                    if (slot_rx != idb[m_n]) begin m_st = 0; m_rc = 0; end
                    else if (m_n == 63) begin m_st = 5; m_rc = 1; end
                    else m_n++;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            total++;
            if (tx_bit !== m_tx() || mem_sel !== (m_st == 5) ||
                rc_flag !== m_rc[0] || od_mode !== m_od[0]) begin
                bad++;
                $display("FAIL model R12 tx/sel/rc/od act=%b%b%b%b exp=%b%b%b%b",
                         tx_bit, mem_sel, rc_flag, od_mode,
                         m_tx(), (m_st == 5), m_rc[0], m_od[0]);
            end
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%b exp=%b", tag, act, exp);
        end
    endtask

    task automatic slot(input logic b);
        @(negedge clk); slot_stb = 1'b1; slot_rx = b;
        @(negedge clk); slot_stb = 1'b0; slot_rx = 1'b1;
    endtask

    task automatic read_slot(output logic b);
        @(negedge clk); b = tx_bit; slot_stb = 1'b1; slot_rx = tx_bit;
        @(negedge clk); slot_stb = 1'b0; slot_rx = 1'b1;
    endtask

    task automatic busreset();
        @(negedge clk); bus_rst = 1'b1;
        @(negedge clk); bus_rst = 1'b0;
    endtask

    task automatic busreset_with_slot(input logic b);
        @(negedge clk); bus_rst = 1'b1; slot_stb = 1'b1; slot_rx = b;
        @(negedge clk); bus_rst = 1'b0; slot_stb = 1'b0; slot_rx = 1'b1;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) slot(v[i]);
    endtask

    task automatic send_id(input int flip);
        for (int i = 0; i < 64; i++) slot((i == flip) ? !idb[i] : idb[i]);
    endtask

    task automatic power_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk("R13 sel in reset", mem_sel, 1'b0);
        chk("R13 rc in reset", rc_flag, 1'b0);
        chk("R13 od in reset", od_mode, 1'b0);
        chk("R13 tx in reset", tx_bit, 1'b1);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic b, c;
        int crc;
        logic [7:0] fam_rd;
        repeat (3) @(negedge clk);
        chk("R13 sel after reset", mem_sel, 1'b0);
        chk("R13 tx after reset", tx_bit, 1'b1);
        rst_n = 1'b1;

        // R2: slots before any bus reset are ignored
        send_byte(8'hCC);
        chk("R2 no cmd before bus reset", mem_sel, 1'b0);
        chk("R2 idle tx released", tx_bit, 1'b1);

        // R3 / R1: read identifier
        busreset();
        send_byte(8'h33);
        crc = 0;
        for (int i = 0; i < 64; i++) begin
            read_slot(b);
            if (i < 8) fam_rd[i] = b;
            chk("R3 id bit", b, idb[i]);
            if (((crc ^ int'(b)) & 1) != 0) crc = (crc >> 1) ^ 'h8C;
            else crc = crc >> 1;
        end
        chk("R1 family code 4Ah", fam_rd == 8'h4A, 1'b1);
        chk("R1 crc residue zero", crc == 0, 1'b1);
        chk("R3 selected", mem_sel, 1'b1);
        chk("R3 rc cleared", rc_flag, 1'b0);

        // R12: selected slave ignores slots and holds the wire released
        send_byte(8'h00);
        chk("R12 sel held", mem_sel, 1'b1);
        chk("R12 tx released", tx_bit, 1'b1);
        busreset();
        chk("R12 sel dropped by reset", mem_sel, 1'b0);

        // R4 match success, then R7 resume with rc=1
        send_byte(8'h55);
        send_id(-1);
        chk("R4 match selects", mem_sel, 1'b1);
        chk("R4 match sets rc", rc_flag, 1'b1);
        busreset();
        send_byte(8'hA5);
        chk("R7 resume selects", mem_sel, 1'b1);
        chk("R7 resume keeps rc", rc_flag, 1'b1);

        // R4 mismatch at bit 5
        busreset();
        send_byte(8'h55);
        for (int i = 0; i < 64; i++) begin
            slot((i == 5) ? !idb[i] : idb[i]);
            if (i == 5) chk("R4 rc cleared at mismatch", rc_flag, 1'b0);
        end
        chk("R4 mismatch not selected", mem_sel, 1'b0);
        chk("R4 tx released after drop", tx_bit, 1'b1);

        // R7 resume with rc=0
        busreset();
        send_byte(8'hA5);
        chk("R7 resume refused", mem_sel, 1'b0);

        // R5 search success
        busreset();
        send_byte(8'hF0);
        for (int i = 0; i < 64; i++) begin
            read_slot(b);
            read_slot(c);
            if (i < 6 || i > 60) begin
                chk("R5 search true bit", b, idb[i]);
                chk("R5 search complement", c, !idb[i]);
            end
            slot(idb[i]);
        end
        chk("R5 search selects", mem_sel, 1'b1);
        chk("R5 search sets rc", rc_flag, 1'b1);

        // R5 search loses at bit 10
        busreset();
        send_byte(8'hF0);
        for (int i = 0; i < 11; i++) begin
            read_slot(b);
            read_slot(c);
            slot((i == 10) ? !idb[i] : idb[i]);
        end
        chk("R5 search drop rc", rc_flag, 1'b0);
        read_slot(b);
        chk("R5 dropped slave released", b, 1'b1);
        chk("R5 dropped not selected", mem_sel, 1'b0);

        // R6 skip clears rc
        busreset();
        send_byte(8'h55);
        send_id(-1);
        busreset();
        send_byte(8'hCC);
        chk("R6 skip selects", mem_sel, 1'b1);
        chk("R6 skip clears rc", rc_flag, 1'b0);

        // R10 unknown code keeps flags
        busreset();
        send_byte(8'h55);
        send_id(-1);
        busreset();
        send_byte(8'h00);
        send_byte(8'hCC);
        chk("R10 unknown idle", mem_sel, 1'b0);
        chk("R10 unknown keeps rc", rc_flag, 1'b1);
        chk("R10 unknown keeps od", od_mode, 1'b0);

        // R11: abort mid-match keeps rc
        busreset();
        send_byte(8'h55);
        for (int i = 0; i < 20; i++) slot(idb[i]);
        busreset();
        chk("R11 abort not selected", mem_sel, 1'b0);
        chk("R11 abort keeps rc", rc_flag, 1'b1);

        // R9: overdrive-match failing from standard speed
        busreset();
        send_byte(8'h69);
        chk("R9 od set after decode", od_mode, 1'b1);
        send_id(30);
        chk("R9 fail clears od", od_mode, 1'b0);
        chk("R9 fail clears rc", rc_flag, 1'b0);
        chk("R9 fail not selected", mem_sel, 1'b0);

        // R8 overdrive-skip
        busreset();
        send_byte(8'h3C);
        chk("R8 od set", od_mode, 1'b1);
        chk("R8 rc cleared", rc_flag, 1'b0);
        chk("R8 selected", mem_sel, 1'b1);

        // R9: failing from overdrive keeps od; then success
        busreset();
        send_byte(8'h69);
        send_id(0);
        chk("R9 fail keeps prior od", od_mode, 1'b1);
        busreset();
        send_byte(8'h69);
        send_id(-1);
        chk("R9 match selects", mem_sel, 1'b1);
        chk("R9 match sets rc", rc_flag, 1'b1);
        chk("R9 match od", od_mode, 1'b1);

        // R11: reset and slot in the same cycle, slot dropped
        busreset_with_slot(1'b1);
        send_byte(8'hCC);
        chk("R11 same-cycle slot dropped", mem_sel, 1'b1);

        // R11: aborted overdrive-match restores od
        power_reset();
        busreset();
        send_byte(8'h69);
        slot(idb[0]);
        slot(idb[1]);
        chk("R11 od during od-match", od_mode, 1'b1);
        busreset();
        chk("R11 abort restores od", od_mode, 1'b0);
        send_byte(8'hCC);
        chk("R11 fresh command after abort", mem_sel, 1'b1);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule